// File: doc/BRIEF.md
# Process-ID TLB Flush Scanner

This engine walks every slot of a split translation cache, the instruction table and the data table, each with four ways of sixteen indexes. It picks out the entries that belong to one address space, so that their pages can be invalidated. A single-cycle start strobe launches a sweep and carries a process identifier. The engine then drives a slot address to the cache arrays. From the tag word and the attribute word it reads back in the same cycle, it decides whether the slot is live, private and owned by the requested process. Each such slot yields a page-aligned virtual address on the report output.

One slot is examined per clock. A downstream ready input gates the sweep: while ready is low the slot pointer holds and nothing is reported. A busy flag covers the sweep, and a one-cycle done strobe marks its end. The caller decides when a flush is needed. What the receiver of the reports does with them is up to the receiver.

Top module: `pid_flush_scanner`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o and inv_valid_o are low.
- R2: A start_i pulse seen while idle raises busy_o on the next cycle and latches pid_i[7:0] as the requested identifier; the upper bits of pid_i are never compared.
- R3: The slot address on tbl_o, way_o, idx_o starts at zero and advances by one slot per clock in which inv_ready_i is high. idx_o moves fastest, then way_o, then tbl_o (0 = instruction table, 1 = data table). That gives 128 slots.
- R4: A slot matches only when attribute bit 3 (valid) is 1, attribute bit 4 (global) is 0, and tag bits [7:0] equal the latched identifier.
- R5: The reported address is tag bits [31:13] followed by thirteen zero bits.
- R6: For each matching slot examined with inv_ready_i high, inv_valid_o is high for exactly the next cycle, and inv_addr_o holds that slot's address. No other cycle has inv_valid_o high.
- R7: In a cycle with inv_ready_i low the slot address does not move, and inv_valid_o is low on the following cycle.
- R8: After slot 127 is examined, done_o is high for one cycle and busy_o falls in that same cycle. Without stalls busy_o stays high for exactly 128 cycles.
- R9: A start_i pulse while busy_o is high is ignored: the identifier in use and the slot sequence continue unchanged.
- R10: A start_i pulse in the cycle where done_o is high is accepted and begins a new sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a sweep |
| pid_i | input | 32 | Requested identifier; only bits [7:0] are used |
| tbl_o | output | 1 | Table select of the slot being read |
| way_o | output | 2 | Way of the slot being read |
| idx_o | output | 4 | Index of the slot being read |
| tlb_tag_i | input | 32 | Tag word of the addressed slot, same cycle |
| tlb_data_i | input | 32 | Attribute word of the addressed slot, same cycle |
| inv_ready_i | input | 1 | Downstream can take a report; low stalls the sweep |
| inv_valid_o | output | 1 | One-cycle strobe for a page invalidate |
| inv_addr_o | output | 32 | Page-aligned virtual address of the report |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle strobe at the end of a sweep |

## Verification
Two pairs of events can land in the same cycle. When the final slot matches, its report strobe and the done strobe rise together. When a new start arrives exactly as done is high, the end of one sweep and the start of the next share a cycle. The bench places a matching entry in slot 127, so the report count and the address list must be complete in the very cycle done is sampled. It also issues a start on the done cycle and expects busy_o high one cycle later. Random stalls on inv_ready_i are laid over both cases, and every report is compared against an independently computed ordered list of matching pages.

// File: rtl/pid_flush_pkg.sv
package pid_flush_pkg;
  parameter int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  vld;
    word_t addr;
  } report_t;
endpackage

// File: rtl/pid_flush_field.sv
module pid_flush_field #(
  parameter int unsigned N = 16,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o,
  output logic         max_o
);
  localparam logic [W-1:0] MAXV = W'(N - 1);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (inc_i) q <= (q == MAXV) ? '0 : q + 1'b1;
  end

  assign val_o = q;
  assign max_o = (q == MAXV);

  p_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && !max_o |=> val_o == $past(val_o) + W'(1));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i && max_o |=> val_o == '0);
endmodule

// File: rtl/pid_flush_walk.sv
module pid_flush_walk #(
  parameter int unsigned N_TBL = 2,
  parameter int unsigned N_WAY = 4,
  parameter int unsigned N_IDX = 16,
  localparam int unsigned TW = (N_TBL > 1) ? $clog2(N_TBL) : 1,
  localparam int unsigned WW = (N_WAY > 1) ? $clog2(N_WAY) : 1,
  localparam int unsigned IW = (N_IDX > 1) ? $clog2(N_IDX) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [TW-1:0] tbl_o,
  output logic [WW-1:0] way_o,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  logic idx_max, way_max, tbl_max;

  // index fastest, then way, then table
  pid_flush_field #(.N(N_IDX)) u_idx (
    .clk_i, .rst_ni, .clr_i, .inc_i(step_i),
    .val_o(idx_o), .max_o(idx_max));
  pid_flush_field #(.N(N_WAY)) u_way (
    .clk_i, .rst_ni, .clr_i, .inc_i(step_i && idx_max),
    .val_o(way_o), .max_o(way_max));
  pid_flush_field #(.N(N_TBL)) u_tbl (
    .clk_i, .rst_ni, .clr_i, .inc_i(step_i && idx_max && way_max),
    .val_o(tbl_o), .max_o(tbl_max));

  assign last_o = idx_max && way_max && tbl_max;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !clr_i |=> $stable({tbl_o, way_o, idx_o}));
endmodule

// File: rtl/pid_flush_match.sv
module pid_flush_match
  import pid_flush_pkg::*;
#(
  parameter int unsigned PID_W      = 8,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned VALID_BIT  = 3,
  parameter int unsigned GLOBAL_BIT = 4
) (
  input  word_t            tag_i,
  input  word_t            data_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             hit_o,
  output word_t            page_o
);
  logic own;

  assign own    = (tag_i[PID_W-1:0] == pid_i);
  assign hit_o  = data_i[VALID_BIT] && !data_i[GLOBAL_BIT] && own;
  assign page_o = (tag_i >> PAGE_SHIFT) << PAGE_SHIFT;
endmodule

// File: rtl/pid_flush_scanner.sv
module pid_flush_scanner
  import pid_flush_pkg::*;
#(
  parameter int unsigned N_TBL      = 2,
  parameter int unsigned N_WAY      = 4,
  parameter int unsigned N_IDX      = 16,
  parameter int unsigned PID_IN_W   = 32,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned VALID_BIT  = 3,
  parameter int unsigned GLOBAL_BIT = 4,
  localparam int unsigned TW = (N_TBL > 1) ? $clog2(N_TBL) : 1,
  localparam int unsigned WW = (N_WAY > 1) ? $clog2(N_WAY) : 1,
  localparam int unsigned IW = (N_IDX > 1) ? $clog2(N_IDX) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PID_IN_W-1:0] pid_i,
  output logic [TW-1:0]       tbl_o,
  output logic [WW-1:0]       way_o,
  output logic [IW-1:0]       idx_o,
  input  logic [WORD_W-1:0]   tlb_tag_i,
  input  logic [WORD_W-1:0]   tlb_data_i,
  input  logic                inv_ready_i,
  output logic                inv_valid_o,
  output logic [WORD_W-1:0]   inv_addr_o,
  output logic                busy_o,
  output logic                done_o
);
  logic             busy_q, done_q;
  logic [PID_W-1:0] pid_q;
  report_t          rep_q;
  logic             start_acc, adv, last, hit;
  word_t            page;

  assign start_acc = start_i && !busy_q;
  assign adv       = busy_q && inv_ready_i;

  pid_flush_walk #(.N_TBL(N_TBL), .N_WAY(N_WAY), .N_IDX(N_IDX)) u_walk (
    .clk_i, .rst_ni, .clr_i(start_acc), .step_i(adv),
    .tbl_o, .way_o, .idx_o, .last_o(last));

  pid_flush_match #(
    .PID_W(PID_W), .PAGE_SHIFT(PAGE_SHIFT),
    .VALID_BIT(VALID_BIT), .GLOBAL_BIT(GLOBAL_BIT)
  ) u_match (
    .tag_i(tlb_tag_i), .data_i(tlb_data_i), .pid_i(pid_q),
    .hit_o(hit), .page_o(page));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pid_q  <= '0;
      rep_q  <= '0;
    end else begin
      done_q    <= adv && last;
      rep_q.vld <= adv && hit;
      if (adv && hit) rep_q.addr <= page;
      if (start_acc) begin
        busy_q <= 1'b1;
        pid_q  <= pid_i[PID_W-1:0];
      end else if (adv && last) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign inv_valid_o = rep_q.vld;
  assign inv_addr_o  = rep_q.addr;

  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(pid_q));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_rep_in_scan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> $past(busy_q && inv_ready_i));
  p_stall_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !inv_ready_i |=> !inv_valid_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
endmodule

// File: tb/pid_flush_scanner_bench.sv
module pid_flush_scanner_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] pid_i = '0;
  logic        tbl_o;
  logic [1:0]  way_o;
  logic [3:0]  idx_o;
  logic [31:0] tlb_tag_i, tlb_data_i;
  logic        inv_ready_i = 1'b1;
  logic        inv_valid_o;
  logic [31:0] inv_addr_o;
  logic        busy_o, done_o;

  logic [31:0] tag_mem [128];
  logic [31:0] data_mem[128];
  logic [31:0] exp_addr[128];
  int exp_n, exp_pos, rep_ptr, busy_cyc;
  int checks = 0, fails = 0, cyc = 0;
  int rdy_mode = 0;
  logic mon_on = 1'b0, pend = 1'b0, stalled = 1'b0;
  logic [7:0] cur_pid;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  pid_flush_scanner u_pid_flush_scanner (
    .clk_i, .rst_ni, .start_i, .pid_i, .tbl_o, .way_o, .idx_o,
    .tlb_tag_i, .tlb_data_i, .inv_ready_i, .inv_valid_o, .inv_addr_o,
    .busy_o, .done_o);

  assign tlb_tag_i  = tag_mem[{tbl_o, way_o, idx_o}];
  assign tlb_data_i = data_mem[{tbl_o, way_o, idx_o}];

  always @(posedge clk_i) begin
    #1;
    inv_ready_i = (rdy_mode == 0) ? 1'b1 : (($urandom % 4) != 0);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input int e, input logic [7:0] p);
    return data_mem[e][3] && !data_mem[e][4] && (tag_mem[e][7:0] == p);
  endfunction

  task automatic build_exp(input logic [7:0] p);
    exp_n = 0;
    for (int e = 0; e < 128; e++)
      if (model_hit(e, p)) begin
        exp_addr[exp_n] = {tag_mem[e][31:13], 13'b0};
        exp_n++;
      end
  endtask

  // monitor: position (R3/R7), report timing (R6), report content (R4, R5)
  always @(negedge clk_i) if (mon_on) begin
    chk(inv_valid_o == pend, "R6 strobe", inv_valid_o, pend);
    if (inv_valid_o) begin
      chk(rep_ptr < exp_n && inv_addr_o == exp_addr[rep_ptr % 128], "R4 R5 addr",
          inv_addr_o, exp_addr[rep_ptr % 128]);
      rep_ptr++;
    end
    pend = 1'b0;
    if (busy_o) begin
      busy_cyc++;
      chk({tbl_o, way_o, idx_o} == exp_pos[6:0], stalled ? "R7 hold" : "R3 order",
          {tbl_o, way_o, idx_o}, exp_pos);
      if (inv_ready_i) begin
        pend = model_hit(exp_pos % 128, cur_pid);
        exp_pos++;
      end
      stalled = !inv_ready_i;
    end
  end

  task automatic fill_random(input logic [7:0] p);
    for (int e = 0; e < 128; e++) begin
      tag_mem[e]  = $urandom;
      if ($urandom % 2) tag_mem[e][7:0] = p;
      data_mem[e] = $urandom;
    end
  endtask

  task automatic run_flush(input logic [31:0] p, input int mode, input bit poke);
    cur_pid = p[7:0];
    build_exp(cur_pid);
    exp_pos = 0; rep_ptr = 0; busy_cyc = 0; pend = 1'b0; stalled = 1'b0;
    rdy_mode = mode;
    @(negedge clk_i);
    start_i = 1'b1; pid_i = p;
    @(negedge clk_i);
    start_i = 1'b0;
    mon_on = 1'b1;
    chk(busy_o, "R2 busy", busy_o, 1);
    for (int n = 0; n < 2000 && !done_o; n++) begin
      @(negedge clk_i);
      if (poke && n == 20) begin
        start_i = 1'b1; pid_i = ~p;   // R9: must be ignored
      end else start_i = 1'b0;
    end
    start_i = 1'b0;
    #1;
    chk(done_o && !busy_o, "R8 done", {done_o, busy_o}, 2'b10);
    chk(rep_ptr == exp_n, poke ? "R9 count" : "R8 count", rep_ptr, exp_n);
    chk(exp_pos == 128, "R8 slots", exp_pos, 128);
    if (mode == 0) chk(busy_cyc == 128, "R8 length", busy_cyc, 128);
    @(negedge clk_i);
    chk(!done_o && !inv_valid_o, "R8 pulse", {done_o, inv_valid_o}, 0);
    mon_on = 1'b0;
    rdy_mode = 0;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7311));
    for (int e = 0; e < 128; e++) begin
      tag_mem[e] = '0; data_mem[e] = '0;
    end
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !inv_valid_o, "R1 in reset", {busy_o, done_o, inv_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !inv_valid_o, "R1 after reset", {busy_o, done_o, inv_valid_o}, 0);

    // directed: first slot, back-to-back, last slot, global and invalid decoys
    tag_mem[0]   = 32'hAAAA_E05A; data_mem[0]   = 32'h8;
    tag_mem[1]   = 32'h1234_5F5A; data_mem[1]   = 32'h8;
    tag_mem[2]   = 32'hFFFF_FF5A; data_mem[2]   = 32'hF;
    tag_mem[3]   = 32'h0000_205A; data_mem[3]   = 32'h18;  // global: skip
    tag_mem[4]   = 32'h0000_405A; data_mem[4]   = 32'h7;   // invalid: skip
    tag_mem[5]   = 32'h0000_605B; data_mem[5]   = 32'h8;   // other pid
    tag_mem[127] = 32'h8000_1F5A; data_mem[127] = 32'h8;
    run_flush(32'hDEAD_BE5A, 0, 1'b0);  // upper pid bits ignored (R2)
    run_flush(32'h0000_005A, 1, 1'b0);

    // R10: start in the done cycle
    rdy_mode = 0;
    @(negedge clk_i); start_i = 1'b1; pid_i = 32'h5A;
    @(negedge clk_i); start_i = 1'b0;
    for (int n = 0; n < 300 && !done_o; n++) @(negedge clk_i);
    start_i = 1'b1; pid_i = 32'h11;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o, "R10 restart", busy_o, 1);
    for (int n = 0; n < 300 && !done_o; n++) @(negedge clk_i);
    @(negedge clk_i);

    // random sweeps
    for (int r = 0; r < 8; r++) begin
      automatic logic [31:0] p = $urandom;
      fill_random(p[7:0]);
      if (r == 3) begin
        tag_mem[127][7:0] = p[7:0]; data_mem[127][4:3] = 2'b01;
      end
      run_flush(p, r % 2, r >= 4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule